// File: doc/BRIEF.md
# Glitch-Free Clock Stop Gate

This block sits after the clock synthesis stage and gates two independent groups of running clocks. The first group is a bank of identical processor clocks that share one source. The second is a single reference clock for the peripheral bus. Each group has its own asynchronous, active-low stop request. The block synchronizes that request into the clock it controls, then parks the clock at logic 0.

Stopping and restarting happen only while the source clock is low. A gated output therefore never shows a shortened high or low phase, and the first high phase after a restart is full width. The processor stop request usually comes from control logic timed to the rising edge of the free-running bus clock. Each group also reports a stopped flag in its own clock domain.

Top module: `clk_stop_gate`

## Requirements
- R1: While the processor group is gated, all CPU_W outputs of `cpu_clk_o` sit at 0. At any moment every bit of the bank carries the same value.
- R2: While the bus group is gated, `pci_clk_o` sits at 0.
- R3: Each stop request is sampled on the falling edges of its own source clock through two flops. The request level sampled at falling edge N decides whether the high phase after falling edge N+1 appears at the output: a level of 0 suppresses that phase and a level of 1 passes it.
- R4: A gated output rises only when its source rises and falls only when its source falls. Every high pulse that appears is full width, and the output is always 0 while the source is low.
- R5: The stop request of one group has no effect on the other group's output or stopped flag.
- R6: Each stopped flag rises at the first source rising edge whose high phase is suppressed. It falls at the first rising edge whose high phase is passed again.
- R7: While `rst_ni` is low, both groups run and both stopped flags read 0, whatever the stop requests are. After reset is released, the synchronizers start from the running state, so at least the two high phases after release pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| cpu_clk_i | input | 1 | Free-running source for the processor clock bank |
| pci_clk_i | input | 1 | Free-running source for the bus reference clock |
| cpu_stop_ni | input | 1 | Asynchronous processor-group stop request, active low |
| pci_stop_ni | input | 1 | Asynchronous bus-group stop request, active low |
| cpu_clk_o | output | CPU_W | Gated processor clock bank |
| pci_clk_o | output | 1 | Gated bus reference clock |
| cpu_stopped_o | output | 1 | Processor group stopped flag, in the cpu_clk_i domain |
| pci_stopped_o | output | 1 | Bus group stopped flag, in the pci_clk_i domain |

## Verification
A synchronizer that is one stage short or one stage long moves every stop and restart by one source cycle. That shows up at the output's first mid-high sample after the request changes. An enable updated on the wrong clock edge would clip a high phase, and the bench catches this at the output edge where the clip happens. A stuck or inverted stopped flag disagrees with the output within one rising edge. Any coupling between the two groups shows on the untouched group at its first high phase.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;
  timeunit 1ns;
  timeprecision 1ps;
  localparam int unsigned CPU_W_DEF = 12;
  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/clk_stop_sync.sv
module clk_stop_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_ni,
  output logic run_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STAGES-1:0] q;

  // falling-edge chain: its output only changes while clk_i is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '1;
    else         q <= {q[STAGES-2:0], req_ni};
  end

  assign run_o = q[STAGES-1];
endmodule

// File: rtl/clk_and_gate.sv
module clk_and_gate #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         en_i,
  output logic [W-1:0] clk_o
);
  timeunit 1ns;
  timeprecision 1ps;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign clk_o[i] = clk_i & en_i;
  end
endmodule

// File: rtl/clk_stop_group.sv
module clk_stop_group #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stop_ni,
  output logic [W-1:0] clk_o,
  output logic         stopped_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic run;
  logic stopped_q;

  clk_stop_sync #(.STAGES(STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (stop_ni),
    .run_o  (run)
  );

  clk_and_gate #(.W(W)) u_gate (
    .clk_i (clk_i),
    .en_i  (run),
    .clk_o (clk_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stopped_q <= 1'b0;
    else         stopped_q <= ~run;
  end

  assign stopped_o = stopped_q;
endmodule

// File: rtl/clk_stop_gate.sv
module clk_stop_gate
  import clk_stop_pkg::*;
#(
  parameter int unsigned CPU_W       = CPU_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic             rst_ni,
  input  logic             cpu_clk_i,
  input  logic             pci_clk_i,
  input  logic             cpu_stop_ni,
  input  logic             pci_stop_ni,
  output logic [CPU_W-1:0] cpu_clk_o,
  output logic             pci_clk_o,
  output logic             cpu_stopped_o,
  output logic             pci_stopped_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [0:0] pci_bank;

  clk_stop_group #(.W(CPU_W), .STAGES(SYNC_STAGES)) u_cpu (
    .clk_i     (cpu_clk_i),
    .rst_ni    (rst_ni),
    .stop_ni   (cpu_stop_ni),
    .clk_o     (cpu_clk_o),
    .stopped_o (cpu_stopped_o)
  );

  clk_stop_group #(.W(1), .STAGES(SYNC_STAGES)) u_pci (
    .clk_i     (pci_clk_i),
    .rst_ni    (rst_ni),
    .stop_ni   (pci_stop_ni),
    .clk_o     (pci_bank),
    .stopped_o (pci_stopped_o)
  );

  assign pci_clk_o = pci_bank[0];
endmodule

// File: rtl/clk_stop_gate_chk.sv
module clk_stop_gate_chk #(
  parameter int unsigned CPU_W = 12
) (
  input logic             rst_ni,
  input logic             cpu_clk_i,
  input logic             pci_clk_i,
  input logic             cpu_stop_ni,
  input logic             pci_stop_ni,
  input logic [CPU_W-1:0] cpu_clk_o,
  input logic             pci_clk_o,
  input logic             cpu_stopped_o,
  input logic             pci_stopped_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0] cpu_seen, pci_seen;

  always_ff @(negedge cpu_clk_i or negedge rst_ni) begin
    if (!rst_ni)                cpu_seen <= '0;
    else if (cpu_seen != 2'd3)  cpu_seen <= cpu_seen + 2'd1;
  end

  always_ff @(negedge pci_clk_i or negedge rst_ni) begin
    if (!rst_ni)                pci_seen <= '0;
    else if (pci_seen != 2'd3)  pci_seen <= pci_seen + 2'd1;
  end

  AST_CPU_HELD_LOW: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    cpu_stopped_o |-> (cpu_clk_o == '0)); // R1
  AST_CPU_BANK_UNIFORM: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    ($countones(cpu_clk_o) == 0) || ($countones(cpu_clk_o) == CPU_W)); // R1
  AST_PCI_HELD_LOW: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
    pci_stopped_o |-> !pci_clk_o); // R2
  AST_CPU_LATENCY: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    (cpu_seen >= 2'd2) |-> (cpu_clk_o[0] == $past(cpu_stop_ni, 2))); // R3
  AST_PCI_LATENCY: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
    (pci_seen >= 2'd2) |-> (pci_clk_o == $past(pci_stop_ni, 2))); // R3
  AST_CPU_FLAG_CLEAR: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    cpu_clk_o[0] |-> !cpu_stopped_o); // R6
  AST_CPU_FLAG_SET: assert property (@(negedge cpu_clk_i) disable iff (!rst_ni)
    !cpu_clk_o[0] |-> cpu_stopped_o); // R6
  AST_PCI_FLAG_MATCH: assert property (@(negedge pci_clk_i) disable iff (!rst_ni)
    pci_clk_o != pci_stopped_o); // R6
endmodule

bind clk_stop_gate clk_stop_gate_chk #(.CPU_W(CPU_W)) u_chk (
  .rst_ni        (rst_ni),
  .cpu_clk_i     (cpu_clk_i),
  .pci_clk_i     (pci_clk_i),
  .cpu_stop_ni   (cpu_stop_ni),
  .pci_stop_ni   (pci_stop_ni),
  .cpu_clk_o     (cpu_clk_o),
  .pci_clk_o     (pci_clk_o),
  .cpu_stopped_o (cpu_stopped_o),
  .pci_stopped_o (pci_stopped_o)
);

// File: tb/tb_clk_stop_gate.sv
module tb_clk_stop_gate;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int unsigned NCPU = 12;

  logic rst_ni = 1'b1;
  logic cpu_clk_i = 1'b0;
  logic pci_clk_i = 1'b0;
  logic cpu_stop_ni = 1'b1;
  logic pci_stop_ni = 1'b1;
  logic [NCPU-1:0] cpu_clk_o;
  logic pci_clk_o, cpu_stopped_o, pci_stopped_o;

  int errors = 0;
  int checks = 0;

  clk_stop_gate #(.CPU_W(NCPU)) dut (
    .rst_ni(rst_ni), .cpu_clk_i(cpu_clk_i), .pci_clk_i(pci_clk_i),
    .cpu_stop_ni(cpu_stop_ni), .pci_stop_ni(pci_stop_ni),
    .cpu_clk_o(cpu_clk_o), .pci_clk_o(pci_clk_o),
    .cpu_stopped_o(cpu_stopped_o), .pci_stopped_o(pci_stopped_o)
  );

  initial forever #4 cpu_clk_i = ~cpu_clk_i;
  initial begin #1; forever #8 pci_clk_i = ~pci_clk_i; end

  // reference: two falling-edge samples decide each high phase (R3, R7)
  logic c_s1 = 1'b1, c_en = 1'b1, c_st = 1'b0;
  logic p_s1 = 1'b1, p_en = 1'b1, p_st = 1'b0;

  always @(negedge cpu_clk_i or negedge rst_ni)
    if (!rst_ni) begin c_s1 <= 1'b1; c_en <= 1'b1; end
    else begin c_en <= c_s1; c_s1 <= cpu_stop_ni; end
  always @(posedge cpu_clk_i or negedge rst_ni)
    if (!rst_ni) c_st <= 1'b0; else c_st <= ~c_en;
  always @(negedge pci_clk_i or negedge rst_ni)
    if (!rst_ni) begin p_s1 <= 1'b1; p_en <= 1'b1; end
    else begin p_en <= p_s1; p_s1 <= pci_stop_ni; end
  always @(posedge pci_clk_i or negedge rst_ni)
    if (!rst_ni) p_st <= 1'b0; else p_st <= ~p_en;

  function automatic logic [NCPU-1:0] exp_bank(input logic en);
    return en ? '1 : '0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  // mid-high samples: output level and flag vs reference (R1 R2 R3 R5 R6 R7)
  always @(posedge cpu_clk_i) begin
    #2;
    chk(cpu_clk_o === exp_bank(c_en), rst_ni ? "R1/R3/R5 cpu bank" : "R7 cpu bank in reset",
        32'(cpu_clk_o), 32'(exp_bank(c_en)));
    chk(cpu_stopped_o === c_st, rst_ni ? "R6 cpu flag" : "R7 cpu flag in reset",
        32'(cpu_stopped_o), 32'(c_st));
  end
  always @(posedge pci_clk_i) begin
    #4;
    chk(pci_clk_o === p_en, rst_ni ? "R2/R3/R5 pci out" : "R7 pci out in reset",
        32'(pci_clk_o), 32'(p_en));
    chk(pci_stopped_o === p_st, rst_ni ? "R6 pci flag" : "R7 pci flag in reset",
        32'(pci_stopped_o), 32'(p_st));
  end
  // mid-low samples: outputs always 0 (R4)
  always @(negedge cpu_clk_i) begin
    #2;
    chk(cpu_clk_o === '0, "R4 cpu low phase", 32'(cpu_clk_o), 32'd0);
  end
  always @(negedge pci_clk_i) begin
    #4;
    chk(pci_clk_o === 1'b0, "R4 pci low phase", 32'(pci_clk_o), 32'd0);
  end
  // edge monitors: an output edge must match the source edge (R4)
  always @(cpu_clk_o[0])
    chk(cpu_clk_o[0] === cpu_clk_i, "R4 cpu edge alignment", 32'(cpu_clk_o[0]), 32'(cpu_clk_i));
  always @(pci_clk_o)
    chk(pci_clk_o === pci_clk_i, "R4 pci edge alignment", 32'(pci_clk_o), 32'(pci_clk_i));

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic pci_cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge pci_clk_i);
    #1;
  endtask

  initial begin
    void'($urandom(32'd4242));
    #1 rst_ni = 1'b0;
    cpu_stop_ni = 1'b0;   // R7: requests ignored while in reset
    pci_stop_ni = 1'b0;
    #49 rst_ni = 1'b1;    // release at 50, away from all edges
    pci_cycles(6);        // R7: first phases pass, then stop takes hold
    chk(cpu_clk_o === '0 && cpu_stopped_o, "R1 held after reset release", 32'(cpu_stopped_o), 32'd1);
    cpu_stop_ni = 1'b1;   // R5: cpu restarts while pci stays stopped
    pci_cycles(6);
    chk(pci_stopped_o === 1'b1, "R5 pci stays stopped", 32'(pci_stopped_o), 32'd1);
    pci_stop_ni = 1'b1;
    pci_cycles(4);
    cpu_stop_ni = 1'b0;   // one bus cycle pulse on cpu request
    pci_cycles(1);
    cpu_stop_ni = 1'b1;
    pci_cycles(4);
    pci_stop_ni = 1'b0;   // one bus cycle pulse on pci request
    pci_cycles(1);
    pci_stop_ni = 1'b1;
    pci_cycles(4);
    for (int k = 0; k < 400; k++) begin
      if ($urandom_range(3) == 0) cpu_stop_ni = ~cpu_stop_ni;
      if ($urandom_range(3) == 0) pci_stop_ni = ~pci_stop_ni;
      pci_cycles(1);
    end
    cpu_stop_ni = 1'b1;
    pci_stop_ni = 1'b1;
    pci_cycles(4);
    summary();
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end
endmodule